// File: doc/BRIEF.md
# Dual-Compare Jitter-Free PWM Generator

This block turns a free-running 16-bit tick count, supplied from outside and never reset by the block, into a pulse-width-modulated output. Two compare points are held internally. When the count equals the rising compare the output goes high, and when it equals the falling compare the output goes low. Each time a compare point matches, that point alone moves forward by the programmed period, modulo 2^16. The waveform is therefore locked to the counter and has no jitter, and the high and low intervals can each be as short as one tick.

A fixed-period mode pins the rising compare at count zero and the falling compare at the on-time, and never moves them. In this mode the period is the full counter wrap of 65536 ticks. Transitions fire only on exact equality. If the count passes a compare point without ever equalling it, that transition is held back until the count wraps round to the value again. On start the output is low and the falling point is set up from the rising point, so no stale high level can survive setup.

Top module: `dual_cmp_pwm`

## Requirements
- R1: The output goes high on the clock edge that samples the count equal to the rising compare point, and goes low on the edge that samples the count equal to the falling compare point. Both changes are visible after that edge.
- R2: In periodic mode (fixedMode=0) a compare point that matches advances by `period` modulo 2^16. The output rises every `period` ticks and stays high for `onTime` ticks, for 0 < onTime < period.
- R3: The high time and the low time may each be a single tick, for example onTime=1 or onTime=period-1.
- R4: In fixed mode (fixedMode=1) the rising point is count 0 and the falling point is count `onTime`. Neither point moves, so the period is 65536 ticks.
- R5: Transitions need exact equality. If the count jumps past a compare point, the output does not change until the count later equals that point.
- R6: On the first clock edge with `enable` high after being low, the rising point is loaded as count + START_LEAD (default 2) in periodic mode, and the falling point as rising point + onTime. The output is forced low on that edge, even if the count matches. The first rise follows START_LEAD edges later.
- R7: While `enable` is low the output is low combinationally, in the same cycle, and neither compare point moves.
- R8: An onTime of 0 keeps the output low. In periodic mode an onTime greater than or equal to a nonzero period keeps the output high after its first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickCount | input | 16 | Free-running counter value |
| enable | input | 1 | Runs the generator; a rising level restarts it |
| fixedMode | input | 1 | 1 = period fixed at the counter wrap |
| period | input | 16 | Period in ticks (periodic mode) |
| onTime | input | 16 | High time in ticks |
| pwmOut | output | 1 | PWM waveform |

## Verification
On every cycle the assertions check four things. The output is low after a start edge. A point that matched in periodic mode has advanced by exactly the period. Both points stay frozen while disabled or in fixed mode. A zero on-time never lets the output rise. Only the bench scenarios can show the waveform itself: the rise-to-rise spacing and high width across many periods, single-tick intervals, the delay when the count skips past a compare point, the timing of the first rise after enable, and the full-high case.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic load;     // restart: load both compare points, force low
    logic advOn;    // move rising point by one period
    logic advOff;   // move falling point by one period
    logic setOut;   // drive output high
    logic clrOut;   // drive output low
  } pwm_strb_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fixedMode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] onTime,
  input  logic             onHit,
  input  logic             offHit,
  output pwm_strb_t        strb
);
  logic running;
  logic active;
  logic zeroOn;
  logic fullOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= enable;
  end

  assign active = running && enable;
  assign zeroOn = (onTime == '0);
  assign fullOn = !fixedMode && (period != '0) && (onTime >= period);

  always_comb begin
    strb        = '0;
    strb.load   = enable && !running;
    strb.advOn  = active && onHit && !fixedMode;
    strb.advOff = active && offHit && !fixedMode;
    strb.setOut = active && onHit && !zeroOn;
    strb.clrOut = !enable || strb.load || (active && offHit && !fullOn);
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int START_LEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fixedMode,
  input  logic [CNT_W-1:0] tickCount,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] onTime,
  input  pwm_strb_t        strb,
  output logic             onHit,
  output logic             offHit,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] LEAD = CNT_W'(START_LEAD);

  logic [CNT_W-1:0] onCmp;
  logic [CNT_W-1:0] offCmp;
  logic [CNT_W-1:0] startBase;
  logic             outReg;

  assign startBase = fixedMode ? '0 : tickCount + LEAD;
  assign onHit     = (tickCount == onCmp);
  assign offHit    = (tickCount == offCmp);
  assign pwmOut    = outReg && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onCmp  <= '0;
      offCmp <= '0;
      outReg <= 1'b0;
    end else if (strb.load) begin
      onCmp  <= startBase;
      offCmp <= startBase + onTime;
      outReg <= 1'b0;
    end else begin
      if (strb.advOn)  onCmp  <= onCmp + period;
      if (strb.advOff) offCmp <= offCmp + period;
      if (strb.clrOut)      outReg <= 1'b0;
      else if (strb.setOut) outReg <= 1'b1;
    end
  end

  // Start leaves the output low on the following cycle.
  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> !outReg);

  // A matched rising point has moved by exactly one period.
  assert_on_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !fixedMode && onHit && !strb.load)
      |=> (onCmp == $past(onCmp) + $past(period)));

  // While disabled the compare points are frozen.
  assert_frozen_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(onCmp) && $stable(offCmp)));

  // Fixed mode never moves the compare points.
  assert_fixed_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fixedMode && !strb.load) |=> ($stable(onCmp) && $stable(offCmp)));

  // A zero high time never lets the output rise.
  assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (onTime == '0 && !outReg) |=> !outReg);
endmodule

// File: rtl/dual_cmp_pwm.sv
module dual_cmp_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int START_LEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tickCount,
  input  logic             enable,
  input  logic             fixedMode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] onTime,
  output logic             pwmOut
);
  pwm_strb_t strb;
  logic      onHit;
  logic      offHit;

  pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fixedMode(fixedMode),
    .period(period), .onTime(onTime), .onHit(onHit), .offHit(offHit),
    .strb(strb)
  );

  pwm_datapath #(.CNT_W(CNT_W), .START_LEAD(START_LEAD)) u_dp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fixedMode(fixedMode),
    .tickCount(tickCount), .period(period), .onTime(onTime), .strb(strb),
    .onHit(onHit), .offHit(offHit), .pwmOut(pwmOut)
  );
endmodule

// File: tb/tb_dual_cmp_pwm.sv
`timescale 1ns/1ps
module tb_dual_cmp_pwm;
  localparam int LEAD = 2;
  localparam int NV = 6;
  localparam logic [15:0] VEC_PER [NV] = '{16'd10, 16'd7, 16'd7, 16'd100, 16'd2, 16'd3};
  localparam logic [15:0] VEC_ON  [NV] = '{16'd3,  16'd1, 16'd6, 16'd50,  16'd1, 16'd2};

  logic clk = 0, rst_n = 0, enable = 0, fixedMode = 0;
  logic [15:0] cnt = 0, period = 10, onTime = 3;
  logic pwmOut;
  int checks = 0, errors = 0;

  dual_cmp_pwm dut (.clk(clk), .rst_n(rst_n), .tickCount(cnt), .enable(enable),
    .fixedMode(fixedMode), .period(period), .onTime(onTime), .pwmOut(pwmOut));

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cnt <= cnt + 16'd1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic runVec(input logic [15:0] per, input logic [15:0] on);
    int waitN, hi, lo;
    enable = 0; step(2);
    fixedMode = 0; period = per; onTime = on; enable = 1;
    waitN = 0;
    while (!pwmOut && waitN < 200) begin step(1); waitN++; end
    check("R1 first rise", pwmOut, 1);
    for (int k = 0; k < 3; k++) begin
      hi = 0; lo = 0;
      while (pwmOut && hi < 300) begin step(1); hi++; end
      while (!pwmOut && lo < 300) begin step(1); lo++; end
      check("R2/R3 high ticks", hi, on);
      check("R2/R3 period ticks", hi + lo, per);
    end
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] c0;
    step(3);
    check("R7 reset output", pwmOut, 0);
    rst_n = 1; step(2);
    check("R7 idle low", pwmOut, 0);

    // Table-driven periodic cases (R2, R3)
    for (int v = 0; v < NV; v++) runVec(VEC_PER[v], VEC_ON[v]);

    // R6: start timing, output low until START_LEAD edges after start edge
    enable = 0; step(2);
    period = 10; onTime = 3; enable = 1;
    for (int i = 1; i <= LEAD; i++) begin step(1); check("R6 low before first rise", pwmOut, 0); end
    step(1); check("R6 first rise", pwmOut, 1);
    step(2); check("R1 still high", pwmOut, 1);
    step(1); check("R1 fall at off point", pwmOut, 0);

    // R7: disable drops output in the same cycle
    while (!pwmOut) step(1);
    enable = 0; #1;
    check("R7 immediate low", pwmOut, 0);
    n = 0;
    for (int i = 0; i < 30; i++) begin step(1); n += pwmOut; end
    check("R7 stays low", n, 0);

    // R5: count jumps past the rising point
    step(1); c0 = cnt; enable = 1;
    step(1); cnt = c0 + 16'd20;
    n = 0;
    for (int i = 0; i < 20; i++) begin step(1); n += pwmOut; end
    check("R5 no rise after skip", n, 0);
    cnt = c0;
    step(2); check("R5 low before match", pwmOut, 0);
    step(1); check("R5 rise on later match", pwmOut, 1);

    // R8: zero on-time and full on-time
    enable = 0; step(2);
    period = 8; onTime = 0; enable = 1;
    n = 0;
    for (int i = 0; i < 40; i++) begin step(1); n += pwmOut; end
    check("R8 zero on-time low", n, 0);
    enable = 0; step(2);
    onTime = 8; enable = 1;
    step(LEAD + 1); check("R8 full rises", pwmOut, 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin step(1); n += pwmOut; end
    check("R8 full stays high", n, 40);

    // R4: fixed mode, rise at count 0, fall at onTime, points constant
    enable = 0; step(2);
    fixedMode = 1; onTime = 5; cnt = 16'd65530; enable = 1;
    step(6); check("R4 low before wrap", pwmOut, 0);
    step(1); check("R4 rise at zero", pwmOut, 1);
    step(4); check("R4 high", pwmOut, 1);
    step(1); check("R4 fall at onTime", pwmOut, 0);
    cnt = 16'd65534;
    step(2); check("R4 low before second wrap", pwmOut, 0);
    step(1); check("R4 second rise same point", pwmOut, 1);

    enable = 0; step(2);
    finish_run();
  end
endmodule